// File: doc/BRIEF.md
# Bus Acquisition Controller with Bounded Handshake

This block lets a local controller take the memory bus away from an external processor and hand it back. It tracks two things in one four-valued mode register: whether the processor is held in reset or running, and whether the bus is currently owned. Single-cycle commands move it between these modes. Some moves finish at once. A request for the bus lowers the active-low bus-request line and then waits for the processor's active-low acknowledge.

That wait is bounded. A prescaler turns the system clock into a slow tick, and a down-counter of ticks limits how long the block waits for the acknowledge. If the wait expires, the block undoes every pin change the request made and leaves the mode as it was. The requester sees a one-cycle completion pulse and the resulting mode. The low bit of the mode tells it whether the bus was won. A bus-cycle command briefly gives the bus back to the processor while it is owned, then takes it again under the same bounded wait.

Top module: `bus_grab_ctrl`

## Requirements
- R1: While and after reset, `mode` is 0, `busreq_n` is 1, `cpu_rst_n` is 0, and `addr_drv_en`, `busy` and `done` are 0.
- R2: Mode codes are 0 halted, 1 halted and owned, 2 running, 3 running and owned. `acquired` equals bit 0 of `mode`. Command codes on `cmd_op` are 0 reset, 1 request, 2 release, 3 run, 4 restart and 5 bus-cycle. A command that needs no wait raises `done` for exactly one cycle, starting the cycle after it is presented.
- R3: The reset command moves any mode to 0 and sets the pins to `busreq_n`=1, `cpu_rst_n`=0 and `addr_drv_en`=0.
- R4: A request in mode 0 drives `busreq_n` low and `cpu_rst_n` high, then waits. When the synchronized acknowledge is seen low, it sets `addr_drv_en` and ends in mode 1. `addr_drv_en` stays low until then.
- R5: A request in mode 2 drives `busreq_n` low and, on acknowledge, ends in mode 3 with `addr_drv_en` set.
- R6: Release moves mode 1 to mode 0 and mode 3 to mode 2, raising `busreq_n` and clearing `addr_drv_en`. Leaving mode 1 also drives `cpu_rst_n` low.
- R7: Run moves mode 0 to 2 and mode 1 to 3, with `cpu_rst_n` high. Restart leaves modes 2 and 3 and their pins unchanged.
- R8: The following complete with `done` and change neither mode nor pins: request in an owned mode, release or restart in an unowned mode, run in a running mode, bus-cycle outside mode 3, restart in a halted mode, and the unused codes 6 and 7.
- R9: With no acknowledge, a wait ends exactly TIMEOUT_TICKS×TICK_DIV+1 cycles after it starts. The mode is unchanged, the pins return to their values for that mode, and `acquired` is 0.
- R10: If the synchronized acknowledge and the expiry fall in the same cycle, the acknowledge wins and the bus is taken.
- R11: Bus-cycle in mode 3 raises `busreq_n` and clears `addr_drv_en` for PULSE_CYCLES cycles, then lowers `busreq_n` and waits as a request does. On acknowledge it ends in mode 3. On expiry it ends in mode 2 with `busreq_n` high.
- R12: `busy` is high while a pulse or wait is in progress. Commands presented during that time are ignored and produce no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code |
| busack_n | input | 1 | Processor bus acknowledge, active low, asynchronous |
| busreq_n | output | 1 | Bus request to processor, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| addr_drv_en | output | 1 | Enable for the local address-bus drivers |
| busy | output | 1 | A pulse or acknowledge wait is in progress |
| done | output | 1 | One-cycle completion pulse |
| mode | output | 2 | Current mode code |
| acquired | output | 1 | Bus is owned (mode bit 0) |

## Verification
The acknowledge check and the wait expiry can both fire in the same cycle. The bench provokes this by lowering `busack_n` so that its synchronized copy lands exactly on the cycle the tick counter reaches zero. It then repeats the request with the drop one cycle later. The first run must end with `done` in the expiry cycle, mode 1 and the address drivers on. The second must end in that same cycle with mode 0 and all request pins restored.

// File: rtl/bgc_pkg.sv
// Shared types for the bus acquisition controller.
// Assumes: mode bit 0 means "bus owned", mode bit 1 means "processor running".
package bgc_pkg;

    typedef enum logic [1:0] {
        MODE_HALT     = 2'd0,
        MODE_HALT_OWN = 2'd1,
        MODE_RUN      = 2'd2,
        MODE_RUN_OWN  = 2'd3
    } bus_mode_t;

    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_REQUEST = 3'd1,
        OP_RELEASE = 3'd2,
        OP_RUN     = 3'd3,
        OP_RESTART = 3'd4,
        OP_MCYCLE  = 3'd5
    } bus_op_t;

    typedef struct packed {
        logic busreq_n;
        logic cpu_rst_n;
        logic addr_en;
    } pin_set_t;

    // Settled pin levels for a mode when no wait is in progress.
    function automatic pin_set_t idle_pins(bus_mode_t m);
        pin_set_t p;
        p.busreq_n  = ~m[0];
        p.cpu_rst_n = m[1] | m[0];
        p.addr_en   = m[0];
        return p;
    endfunction

endpackage

// File: rtl/bgc_sync.sv
// Multi-stage synchronizer for an active-low asynchronous input.
// Assumes: STAGES >= 1; resets to the idle (high) level.
module bgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic dout_n
);
    logic [STAGES-1:0] chain;

    // Shift the input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= din_n;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout_n = chain[STAGES-1];
endmodule

// File: rtl/bgc_tick_gen.sv
// Prescaler: emits one tick every DIV clocks, restartable so that a wait
// window always starts on a fresh prescaler period.
// Assumes: DIV >= 1.
module bgc_tick_gen #(
    parameter int DIV = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks, wrapping at the last value or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/bgc_timeout.sv
// Tick down-counter bounding the acknowledge wait; sticks at zero.
// Assumes: load has priority over a tick in the same cycle.
module bgc_timeout #(
    parameter int TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] remain;

    // Reload on a new wait, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= TW'(TICKS);
        end else if (tick && remain != '0) begin
            remain <= remain - TW'(1);
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/bgc_seq.sv
// Command sequencer: owns the mode register and the pin registers, starts
// waits and pulses, and resolves acknowledge against expiry.
// Assumes: ack_seen is already synchronized; commands are single-cycle.
module bgc_seq
    import bgc_pkg::*;
#(
    parameter int PULSE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       ack_seen,
    input  logic       expired,
    output logic       load_wait,
    output logic       busreq_n,
    output logic       cpu_rst_n,
    output logic       addr_drv_en,
    output logic       busy,
    output logic       done,
    output logic [1:0] mode
);
    localparam int PW = $clog2(PULSE + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_PULSE, PH_WAIT} phase_t;

    phase_t    phase;
    bus_mode_t mode_q;
    bus_mode_t home_q;
    pin_set_t  pins_q;
    logic      done_q;
    logic [PW-1:0] pulse_left;

    bus_op_t op;
    logic    start_req;
    logic    start_cyc;
    logic    pulse_end;

    // Decode the command and the events that open a bounded wait.
    always_comb begin
        op        = bus_op_t'(cmd_op);
        start_req = (phase == PH_IDLE) && cmd_valid && (op == OP_REQUEST) && !mode_q[0];
        start_cyc = (phase == PH_IDLE) && cmd_valid && (op == OP_MCYCLE) && (mode_q == MODE_RUN_OWN);
        pulse_end = (phase == PH_PULSE) && (pulse_left == PW'(1));
        load_wait = start_req || pulse_end;
    end

    // Mode, pin and phase update for every command and wait outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            mode_q     <= MODE_HALT;
            home_q     <= MODE_HALT;
            pins_q     <= idle_pins(MODE_HALT);
            done_q     <= 1'b0;
            pulse_left <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        done_q <= 1'b1;
                        case (op)
                            OP_RESET: begin
                                mode_q <= MODE_HALT;
                                pins_q <= idle_pins(MODE_HALT);
                            end
                            OP_REQUEST: begin
                                if (start_req) begin
                                    home_q           <= mode_q;
                                    pins_q.busreq_n  <= 1'b0;
                                    pins_q.cpu_rst_n <= 1'b1;
                                    phase            <= PH_WAIT;
                                    done_q           <= 1'b0;
                                end
                            end
                            OP_RELEASE: begin
                                if (mode_q[0]) begin
                                    mode_q <= bus_mode_t'({mode_q[1], 1'b0});
                                    pins_q <= idle_pins(bus_mode_t'({mode_q[1], 1'b0}));
                                end
                            end
                            OP_RUN: begin
                                if (!mode_q[1]) begin
                                    mode_q <= bus_mode_t'({1'b1, mode_q[0]});
                                    pins_q <= idle_pins(bus_mode_t'({1'b1, mode_q[0]}));
                                end
                            end
                            OP_MCYCLE: begin
                                if (start_cyc) begin
                                    home_q          <= MODE_RUN;
                                    pins_q.busreq_n <= 1'b1;
                                    pins_q.addr_en  <= 1'b0;
                                    pulse_left      <= PW'(PULSE);
                                    phase           <= PH_PULSE;
                                    done_q          <= 1'b0;
                                end
                            end
                            default: begin
                            end
                        endcase
                    end
                end
                PH_PULSE: begin
                    if (pulse_end) begin
                        pins_q.busreq_n <= 1'b0;
                        phase           <= PH_WAIT;
                    end else begin
                        pulse_left <= pulse_left - PW'(1);
                    end
                end
                PH_WAIT: begin
                    if (ack_seen) begin
                        pins_q.addr_en <= 1'b1;
                        mode_q         <= bus_mode_t'({home_q[1], 1'b1});
                        phase          <= PH_IDLE;
                        done_q         <= 1'b1;
                    end else if (expired) begin
                        pins_q <= idle_pins(home_q);
                        mode_q <= home_q;
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busreq_n    = pins_q.busreq_n;
    assign cpu_rst_n   = pins_q.cpu_rst_n;
    assign addr_drv_en = pins_q.addr_en;
    assign busy        = (phase != PH_IDLE);
    assign done        = done_q;
    assign mode        = mode_q;
endmodule

// File: rtl/bus_grab_ctrl.sv
// Top of the bus acquisition controller: synchronizes the acknowledge,
// derives the slow tick, bounds the wait and runs the command sequencer.
// Assumes: busack_n is asynchronous to clk; TICK_DIV clocks make one tick.
module bus_grab_ctrl #(
    parameter int TICK_DIV      = 1600000,
    parameter int TIMEOUT_TICKS = 20,
    parameter int PULSE_CYCLES  = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       busack_n,
    output logic       busreq_n,
    output logic       cpu_rst_n,
    output logic       addr_drv_en,
    output logic       busy,
    output logic       done,
    output logic [1:0] mode,
    output logic       acquired
);
    logic ack_sync_n;
    logic ack_seen;
    logic tick;
    logic expired;
    logic load_wait;

    bgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (busack_n),
        .dout_n (ack_sync_n)
    );

    assign ack_seen = ~ack_sync_n;

    bgc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_wait),
        .tick    (tick)
    );

    bgc_timeout #(.TICKS(TIMEOUT_TICKS)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_wait),
        .tick    (tick),
        .expired (expired)
    );

    bgc_seq #(.PULSE(PULSE_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .ack_seen    (ack_seen),
        .expired     (expired),
        .load_wait   (load_wait),
        .busreq_n    (busreq_n),
        .cpu_rst_n   (cpu_rst_n),
        .addr_drv_en (addr_drv_en),
        .busy        (busy),
        .done        (done),
        .mode        (mode)
    );

    assign acquired = mode[0];
endmodule

// File: rtl/bgc_checker.sv
// Property checker for bus_grab_ctrl, attached by bind below.
module bgc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busreq_n,
    input logic       cpu_rst_n,
    input logic       addr_drv_en,
    input logic       busy,
    input logic       done,
    input logic [1:0] mode,
    input logic       acquired,
    input logic       ack_seen
);
    p_addr_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_drv_en) |-> $past(ack_seen));

    p_mode_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode));

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_halt_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode == 2'd0) |-> (busreq_n && !cpu_rst_n && !addr_drv_en));

    p_fail_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !acquired) |-> (busreq_n && !addr_drv_en));

    p_own_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && acquired) |-> (!busreq_n && addr_drv_en && cpu_rst_n));
endmodule

bind bus_grab_ctrl bgc_checker u_bgc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busreq_n    (busreq_n),
    .cpu_rst_n   (cpu_rst_n),
    .addr_drv_en (addr_drv_en),
    .busy        (busy),
    .done        (done),
    .mode        (mode),
    .acquired    (acquired),
    .ack_seen    (ack_seen)
);

// File: tb/test_bus_grab_ctrl.sv
module test_bus_grab_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int TICKS = 5;
    localparam int PULSE = 2;
    localparam int SYNC  = 2;
    localparam int TO_K  = TICKS * DIV + 1;
    localparam int LIMIT = 200;

    localparam logic [2:0] C_RESET = 3'd0, C_REQ = 3'd1, C_REL = 3'd2,
                           C_RUN = 3'd3, C_RESTART = 3'd4, C_MCY = 3'd5;

    // {op[14:12], busack_n[11], mode[10:9], busreq_n[8], cpu_rst_n[7], addr[6], latency[5:0]}
    localparam int NSTEPS = 21;
    localparam logic [14:0] STEPS [NSTEPS] = '{
        {C_REL,     1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R8
        {C_RESTART, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R8
        {C_MCY,     1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R8
        {C_REQ,     1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 6'd1},   // R4
        {C_REQ,     1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 6'd0},   // R8
        {C_RUN,     1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 6'd0},   // R7
        {C_RESTART, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 6'd0},   // R7
        {C_REL,     1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 6'd0},   // R6
        {C_RUN,     1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 6'd0},   // R8
        {C_REL,     1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 6'd0},   // R8
        {C_REQ,     1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 6'd1},   // R5
        {C_MCY,     1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 6'd3},   // R11
        {C_RESET,   1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R3
        {C_REQ,     1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 6'd1},   // R4
        {C_REL,     1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R6
        {C_RUN,     1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 6'd0},   // R7
        {C_RESET,   1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R3
        {3'd7,      1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0},   // R8
        {C_REQ,     1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 6'd21},  // R9
        {C_RUN,     1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 6'd0},   // R7
        {C_REQ,     1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 6'd21}   // R9
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic       busack_n;
    logic       busreq_n, cpu_rst_n, addr_drv_en, busy, done, acquired;
    logic [1:0] mode;

    int n_run  = 0;
    int n_fail = 0;
    int snap_busy, snap_breq, snap_rst, snap_addr;

    bus_grab_ctrl #(
        .TICK_DIV(DIV), .TIMEOUT_TICKS(TICKS),
        .PULSE_CYCLES(PULSE), .SYNC_STAGES(SYNC)
    ) i_bus_grab_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busack_n(busack_n), .busreq_n(busreq_n), .cpu_rst_n(cpu_rst_n),
        .addr_drv_en(addr_drv_en), .busy(busy), .done(done),
        .mode(mode), .acquired(acquired)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pins(input string tag, input int m, input int b, input int r, input int a);
        chk({tag, " mode"}, int'(mode), m);
        chk({tag, " acquired (R2)"}, int'(acquired), m % 2);
        chk({tag, " busreq_n"}, int'(busreq_n), b);
        chk({tag, " cpu_rst_n"}, int'(cpu_rst_n), r);
        chk({tag, " addr_drv_en"}, int'(addr_drv_en), a);
        chk({tag, " busy"}, int'(busy), 0);
    endtask

    task automatic settle_ack(input logic lvl);
        busack_n = lvl;
        repeat (SYNC + 1) @(negedge clk);
    endtask

    // Present op; k counts negedges after the accepting edge until done.
    task automatic run_seq(input logic [2:0] op, input int drop_at, input int poke_at, output int k);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        snap_busy = int'(busy);
        snap_breq = int'(busreq_n);
        snap_rst  = int'(cpu_rst_n);
        snap_addr = int'(addr_drv_en);
        k = 0;
        while (k < LIMIT) begin
            if (done === 1'b1) break;
            if (k == drop_at) busack_n = 1'b0;
            if (k == poke_at) begin
                cmd_valid = 1'b1;
                cmd_op    = C_RESET;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int k;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
        busack_n  = 1'b1;
        repeat (4) @(negedge clk);
        pins("R1 in reset", 0, 1, 0, 0);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        pins("R1 after reset", 0, 1, 0, 0);
        chk("R1 done after reset", int'(done), 0);

        // Vector table walk
        for (int i = 0; i < NSTEPS; i++) begin
            logic [14:0] v;
            v = STEPS[i];
            settle_ack(v[11]);
            run_seq(v[14:12], -1, -1, k);
            chk($sformatf("R2 step %0d latency", i), k, int'(v[5:0]));
            pins($sformatf("step %0d", i), int'(v[10:9]), int'(v[8]), int'(v[7]), int'(v[6]));
            @(negedge clk);
            chk($sformatf("R2 step %0d done width", i), int'(done), 0);
        end

        // R12: command during a wait is ignored; R4: pins during the wait
        settle_ack(1'b1);
        run_seq(C_RESET, -1, -1, k);
        run_seq(C_REQ, 4, 2, k);
        chk("R4 busy while waiting", snap_busy, 1);
        chk("R4 busreq_n while waiting", snap_breq, 0);
        chk("R4 cpu_rst_n while waiting", snap_rst, 1);
        chk("R4 addr off before ack", snap_addr, 0);
        chk("R12 late ack latency", k, 7);
        pins("R12 after ignored reset", 1, 0, 1, 1);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R12 no extra done", int'(done), 0);
        end
        chk("R12 mode kept", int'(mode), 1);

        // R10: ack lands on the expiry cycle, then one cycle late
        settle_ack(1'b1);
        run_seq(C_RESET, -1, -1, k);
        settle_ack(1'b1);
        run_seq(C_REQ, TO_K - 3, -1, k);
        chk("R10 same-cycle latency", k, TO_K);
        pins("R10 ack wins", 1, 0, 1, 1);
        settle_ack(1'b1);
        run_seq(C_RESET, -1, -1, k);
        settle_ack(1'b1);
        run_seq(C_REQ, TO_K - 2, -1, k);
        chk("R10 late ack latency", k, TO_K);
        pins("R10 expiry wins", 0, 1, 0, 0);

        // R11: bus-cycle pulse shape with acknowledge present
        settle_ack(1'b0);
        run_seq(C_RUN, -1, -1, k);
        run_seq(C_REQ, -1, -1, k);
        pins("R11 setup", 3, 0, 1, 1);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = C_MCY;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11 busy k0", int'(busy), 1);
        chk("R11 busreq_n high k0", int'(busreq_n), 1);
        chk("R11 addr off k0", int'(addr_drv_en), 0);
        @(negedge clk);
        chk("R11 busreq_n high k1", int'(busreq_n), 1);
        @(negedge clk);
        chk("R11 busreq_n low k2", int'(busreq_n), 0);
        chk("R11 no done k2", int'(done), 0);
        @(negedge clk);
        chk("R11 done k3", int'(done), 1);
        pins("R11 reacquired", 3, 0, 1, 1);

        // R11: bus-cycle with no acknowledge falls back to running
        settle_ack(1'b1);
        run_seq(C_MCY, -1, -1, k);
        chk("R11 expiry latency", k, PULSE + TO_K);
        pins("R11 expiry", 2, 1, 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule